// File: doc/BRIEF.md
# 64-bit System Timer with Compare Alarms

This block keeps a 64-bit time count that steps by one on every cycle in which a single-cycle tick enable is high. Software reaches it through a plain 32-bit register port with a byte address, a write strobe, a read strobe, write data and combinational read data. Four single-shot alarms each hold a 32-bit target. Each alarm drives one interrupt line through a raw, enable, force and status register set.

A 64-bit value cannot move across a 32-bit port in one access, so the block makes split accesses consistent. A read of the latched low half also captures the high half into a shadow register, and the latched high read returns that shadow. A write of the low half is parked until the high half is written. The high write then loads all 64 bits on one edge. A separate pair of live read addresses returns the counter halves with no side effects.

The count can be frozen by a software bit. It can also be frozen by either of two debug-halt inputs, and each of those inputs has its own enable bit.

Top module: `stime_timer`

## Requirements
- R1: After reset the count is 0, the alarms are disarmed, the raw, enable and force registers read 0, the freeze register reads 0, the halt-enable register at 0x2C reads 0x6 (bits 1 and 2 set), and every `irq` line is low.
- R2: The count increases by exactly one on each clock edge at which `tick` is high and no freeze or halt applies, and carries from the low half into the high half. The live addresses 0x28 (bits 31:0) and 0x24 (bits 63:32) return the current count and change no state.
- R3: While bit 0 of the freeze register at 0x30 is 1, ticks do not change the count.
- R4: Bit 1 of the halt-enable register at 0x2C lets `dbg_halt[0]` stop the count, and bit 2 lets `dbg_halt[1]` stop it. While its enable bit is 0, a halt input has no effect.
- R5: A read with `bus_rd` of address 0x0C returns count bits 31:0 and captures count bits 63:32 into a shadow. Address 0x08 returns that shadow. Reads of other addresses leave the shadow unchanged.
- R6: A write to 0x04 holds bits 31:0 without changing the count. A following write to 0x00 loads {written high, held low} into the count on a single edge.
- R7: A write to alarm address 0x10+4*i sets the target of alarm i and sets bit i of the armed register at 0x20. The target can be read back at the same address.
- R8: An armed alarm fires when its target equals count bits 31:0. On the edge where the count takes that value, raw bit i (0x34) is set and armed bit i is cleared. A fired alarm does not fire again until it is rewritten.
- R9: Writing 1 to bit i of 0x20 disarms alarm i. Writing 1 to bit i of 0x34 clears raw bit i. Zero bits in either write have no effect.
- R10: The enable register (0x38) and force register (0x3C) are read/write. The status register (0x40) and `irq[i]` equal (raw OR force) AND enable.
- R11: When a tick and an alarm match coincide, the compare uses the incremented count. An alarm whose target is count+1 sets its raw bit on that tick's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable |
| dbg_halt | input | 2 | Debug-halt requests, each gated by its own enable bit |
| bus_addr | input | 7 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (enables read side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 4 | Per-alarm interrupt lines |

## Verification
The count is loaded just below a 32-bit boundary and ticked across it. This shows that the carry reaches the high half and that a held low write stays invisible until the high write commits. Latched reads are interleaved with live reads and with a fresh load, which separates a shadow that is captured only on low reads from one that follows the counter. Alarms are tried with a target reached over many ticks, with a target one tick ahead and sampled on that very edge, with a disarmed target that the count passes, and with a counter parked on a fired target. These patterns separate post-increment from pre-increment compare, self-disarm from level firing, and write-one-to-clear from plain writes. The freeze bit, each halt input with its enable set and cleared, and force against enable masking exercise the remaining gating paths.

// File: rtl/stime_pkg.sv
package stime_pkg;
    localparam int OFS_WR_HI  = 'h00;
    localparam int OFS_WR_LO  = 'h04;
    localparam int OFS_RD_HI  = 'h08;
    localparam int OFS_RD_LO  = 'h0C;
    localparam int OFS_CMP0   = 'h10;
    localparam int WORD_BYTES = 4;

    // Count is held when frozen or when an enabled debug halt is active.
    function automatic logic halt_active(input logic freeze,
                                         input logic [1:0] halt_en,
                                         input logic [1:0] dbg);
        return freeze | (|(halt_en & dbg));
    endfunction
endpackage

// File: rtl/stime_counter.sv
module stime_counter #(
    parameter int HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  halt,
    input  logic                  ld_lo,
    input  logic                  ld_hi,
    input  logic [HALF_W-1:0]     wdata,
    input  logic                  snap,
    output logic [2*HALF_W-1:0]   cnt_q,
    output logic [HALF_W-1:0]     cnt_nxt_lo,
    output logic [HALF_W-1:0]     shadow_hi
);
    localparam int CW = 2 * HALF_W;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [HALF_W-1:0] lo_hold;
        logic [HALF_W-1:0] hi_shadow;
    } ctr_t;

    ctr_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (ld_lo)
            st_d.lo_hold = wdata;
        if (ld_hi)
            st_d.cnt = {wdata, st_q.lo_hold};
        else if (tick && !halt)
            st_d.cnt = st_q.cnt + CW'(1);
        if (snap)
            st_d.hi_shadow = st_q.cnt[CW-1:HALF_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt_q      = st_q.cnt;
    assign cnt_nxt_lo = st_d.cnt[HALF_W-1:0];
    assign shadow_hi  = st_q.hi_shadow;

    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt && !ld_hi) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R2
    AST_HOLD_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !ld_hi) |=> (cnt_q == $past(cnt_q))); // R3
    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (shadow_hi == $past(cnt_q[CW-1:HALF_W]))); // R5
    AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(shadow_hi)); // R5
endmodule

// File: rtl/stime_alarm.sv
module stime_alarm #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_tgt,
    input  logic         disarm,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] now_lo,
    output logic         armed,
    output logic         fire,
    output logic [W-1:0] target
);
    typedef struct packed {
        logic         armed;
        logic [W-1:0] tgt;
    } alm_t;

    alm_t st_q, st_d;

    assign fire = st_q.armed && (st_q.tgt == now_lo);

    always_comb begin
        st_d = st_q;
        if (wr_tgt) begin
            st_d.armed = 1'b1;
            st_d.tgt   = wdata;
        end else begin
            st_d.armed = st_q.armed & ~fire & ~disarm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign armed  = st_q.armed;
    assign target = st_q.tgt;

    AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tgt |=> (armed && target == $past(wdata))); // R7
    AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_tgt) |=> !armed); // R8
    AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm && !wr_tgt) |=> !armed); // R9
endmodule

// File: rtl/stime_timer.sv
module stime_timer #(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 32,
    parameter int N_ALARM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [1:0]         dbg_halt,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [N_ALARM-1:0] irq
);
    import stime_pkg::*;

    localparam int OFS_ARMED = OFS_CMP0 + WORD_BYTES * N_ALARM;
    localparam int OFS_LV_HI = OFS_ARMED + 1 * WORD_BYTES;
    localparam int OFS_LV_LO = OFS_ARMED + 2 * WORD_BYTES;
    localparam int OFS_HALT  = OFS_ARMED + 3 * WORD_BYTES;
    localparam int OFS_FRZ   = OFS_ARMED + 4 * WORD_BYTES;
    localparam int OFS_RAW   = OFS_ARMED + 5 * WORD_BYTES;
    localparam int OFS_EN    = OFS_ARMED + 6 * WORD_BYTES;
    localparam int OFS_FRC   = OFS_ARMED + 7 * WORD_BYTES;
    localparam int OFS_STAT  = OFS_ARMED + 8 * WORD_BYTES;

    typedef struct packed {
        logic [N_ALARM-1:0] raw;
        logic [N_ALARM-1:0] en;
        logic [N_ALARM-1:0] frc;
        logic               freeze;
        logic [1:0]         halt_en;
    } ctl_t;

    ctl_t st_q, st_d;

    logic [2*DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0]   cnt_nxt_lo;
    logic [DATA_W-1:0]   shadow_hi;
    logic [N_ALARM-1:0]  armed, fire, wr_cmp;
    logic [DATA_W-1:0]   target [N_ALARM];
    logic                halt;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign halt = halt_active(st_q.freeze, st_q.halt_en, dbg_halt);

    stime_counter #(.HALF_W(DATA_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .halt       (halt),
        .ld_lo      (bus_wr && hit(bus_addr, OFS_WR_LO)),
        .ld_hi      (bus_wr && hit(bus_addr, OFS_WR_HI)),
        .wdata      (bus_wdata),
        .snap       (bus_rd && hit(bus_addr, OFS_RD_LO)),
        .cnt_q      (cnt_q),
        .cnt_nxt_lo (cnt_nxt_lo),
        .shadow_hi  (shadow_hi)
    );

    for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
        assign wr_cmp[i] = bus_wr && hit(bus_addr, OFS_CMP0 + WORD_BYTES * i);
        stime_alarm #(.W(DATA_W)) u_alm (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_tgt (wr_cmp[i]),
            .disarm (bus_wr && hit(bus_addr, OFS_ARMED) && bus_wdata[i]),
            .wdata  (bus_wdata),
            .now_lo (cnt_nxt_lo),
            .armed  (armed[i]),
            .fire   (fire[i]),
            .target (target[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (hit(bus_addr, OFS_EN))   st_d.en      = bus_wdata[N_ALARM-1:0];
            if (hit(bus_addr, OFS_FRC))  st_d.frc     = bus_wdata[N_ALARM-1:0];
            if (hit(bus_addr, OFS_FRZ))  st_d.freeze  = bus_wdata[0];
            if (hit(bus_addr, OFS_HALT)) st_d.halt_en = bus_wdata[2:1];
            if (hit(bus_addr, OFS_RAW))  st_d.raw     = st_q.raw & ~bus_wdata[N_ALARM-1:0];
        end
        st_d.raw = st_d.raw | fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.halt_en <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = (st_q.raw | st_q.frc) & st_q.en;

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFS_RD_HI)) bus_rdata = shadow_hi;
        if (hit(bus_addr, OFS_RD_LO)) bus_rdata = cnt_q[DATA_W-1:0];
        if (hit(bus_addr, OFS_LV_HI)) bus_rdata = cnt_q[2*DATA_W-1:DATA_W];
        if (hit(bus_addr, OFS_LV_LO)) bus_rdata = cnt_q[DATA_W-1:0];
        if (hit(bus_addr, OFS_ARMED)) bus_rdata = DATA_W'(armed);
        if (hit(bus_addr, OFS_HALT))  bus_rdata = DATA_W'({st_q.halt_en, 1'b0});
        if (hit(bus_addr, OFS_FRZ))   bus_rdata = DATA_W'(st_q.freeze);
        if (hit(bus_addr, OFS_RAW))   bus_rdata = DATA_W'(st_q.raw);
        if (hit(bus_addr, OFS_EN))    bus_rdata = DATA_W'(st_q.en);
        if (hit(bus_addr, OFS_FRC))   bus_rdata = DATA_W'(st_q.frc);
        if (hit(bus_addr, OFS_STAT))  bus_rdata = DATA_W'(irq);
        for (int i = 0; i < N_ALARM; i++)
            if (hit(bus_addr, OFS_CMP0 + WORD_BYTES * i)) bus_rdata = target[i];
    end

    AST_RAW_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> ((st_q.raw & $past(fire)) == $past(fire))); // R8
    AST_RAW_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit(bus_addr, OFS_RAW) && !(|fire)) |=>
        ((st_q.raw & $past(bus_wdata[N_ALARM-1:0])) == '0)); // R9
endmodule

// File: tb/stime_timer_tb.sv
module stime_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  dbg_halt = 2'b00;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stime_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_halt(dbg_halt),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    event  samp;

    // Monitor: pops one expected item per sample and compares it.
    always @(samp) begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.is_irq ? {28'd0, irq} : bus_rdata;
        n_cmp++;
        if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
    end

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a; bus_rd = 1'b1;
        #1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        -> samp;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic [3:0] e, input string tag);
        item_t it;
        #1;
        it.is_irq = 1'b1; it.exp = {28'd0, e}; it.tag = tag;
        sb.push_back(it);
        -> samp;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(7'h28, 32'h0, "R1 live low after reset");
        rd(7'h24, 32'h0, "R1 live high after reset");
        rd(7'h2C, 32'h6, "R1 halt enable reset value");
        rd(7'h20, 32'h0, "R1 armed after reset");
        rd(7'h34, 32'h0, "R1 raw after reset");
        chk_irq(4'h0, "R1 irq after reset");

        // Split write: low held until high write
        wr(7'h04, 32'hFFFF_FFF0);
        rd(7'h28, 32'h0, "R6 low write held back");
        wr(7'h00, 32'h0000_0001);
        rd(7'h28, 32'hFFFF_FFF0, "R6 commit low half");
        rd(7'h24, 32'h0000_0001, "R6 commit high half");

        // Counting with carry
        ticks(20);
        rd(7'h28, 32'h0000_0004, "R2 low after 20 ticks");
        rd(7'h24, 32'h0000_0002, "R2 carry into high half");

        // Latched read versus live read
        rd(7'h0C, 32'h0000_0004, "R5 latched low read");
        wr(7'h04, 32'h0);
        wr(7'h00, 32'h7);
        rd(7'h08, 32'h2, "R5 shadow keeps captured high");
        rd(7'h24, 32'h7, "R2 live high no side effect");
        rd(7'h08, 32'h2, "R5 shadow unchanged by live read");
        rd(7'h0C, 32'h0, "R5 latched low after load");
        rd(7'h08, 32'h7, "R5 shadow recaptured");

        // Freeze
        wr(7'h30, 32'h1);
        ticks(10);
        rd(7'h28, 32'h0, "R3 frozen count");
        wr(7'h30, 32'h0);
        ticks(3);
        rd(7'h28, 32'h3, "R3 counting after unfreeze");

        // Debug halts
        dbg_halt = 2'b01;
        ticks(5);
        rd(7'h28, 32'h3, "R4 halt input 0 enabled");
        wr(7'h2C, 32'h4);
        ticks(5);
        rd(7'h28, 32'h8, "R4 halt input 0 ignored when disabled");
        dbg_halt = 2'b10;
        ticks(5);
        rd(7'h28, 32'h8, "R4 halt input 1 enabled");
        dbg_halt = 2'b00;
        wr(7'h2C, 32'h6);

        // Alarm 0 reached over several ticks
        wr(7'h10, 32'h10);
        rd(7'h20, 32'h1, "R7 write arms alarm 0");
        rd(7'h10, 32'h10, "R7 target readback");
        ticks(8);
        rd(7'h34, 32'h1, "R8 alarm 0 raw set");
        rd(7'h20, 32'h0, "R8 alarm 0 self disarmed");
        chk_irq(4'h0, "R10 irq masked with enable 0");
        wr(7'h34, 32'h1);
        rd(7'h34, 32'h0, "R9 raw cleared by write one");
        rd(7'h34, 32'h0, "R8 no refire while parked on target");

        // Post-increment compare, sampled on the tick edge
        wr(7'h14, 32'h11);
        ticks(1);
        rd(7'h34, 32'h2, "R11 fire on the incrementing edge");
        rd(7'h20, 32'h0, "R8 alarm 1 self disarmed");

        // Disarm by write one
        wr(7'h18, 32'h20);
        rd(7'h20, 32'h4, "R7 write arms alarm 2");
        wr(7'h20, 32'h4);
        rd(7'h20, 32'h0, "R9 armed bit cleared by write one");
        ticks(15);
        rd(7'h28, 32'h20, "R2 count reached disarmed target");
        rd(7'h34, 32'h2, "R9 disarmed alarm did not fire");
        wr(7'h34, 32'h0);
        rd(7'h34, 32'h2, "R9 zero write leaves raw");
        wr(7'h34, 32'h2);

        // Enable, force, status
        wr(7'h1C, 32'h21);
        ticks(1);
        rd(7'h34, 32'h8, "R8 alarm 3 raw set");
        rd(7'h40, 32'h0, "R10 status masked");
        wr(7'h38, 32'h8);
        chk_irq(4'h8, "R10 irq enabled raw");
        rd(7'h40, 32'h8, "R10 status enabled raw");
        wr(7'h3C, 32'h1);
        chk_irq(4'h8, "R10 force masked by enable");
        wr(7'h38, 32'h9);
        chk_irq(4'h9, "R10 force plus raw");
        rd(7'h3C, 32'h1, "R10 force readback");
        rd(7'h38, 32'h9, "R10 enable readback");
        wr(7'h34, 32'h8);
        chk_irq(4'h1, "R10 force alone after raw clear");

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule